// File: doc/BRIEF.md
# CAN Core Mode and Command Control

This block holds the command byte and the status byte of a CAN core and decides whether the core sits in reset mode or operation mode. Software reads and writes one 16-bit register word through a plain register port with byte enables. The low byte is the command register and the high byte is the status register. The protocol engine and the error counters live elsewhere. Their conditions arrive as level inputs and are captured into the status byte.

The core leaves hardware reset in reset mode. Software sets up the configuration and then clears the reset-request bit to start operation. Several internal events force the reset-request bit back to one: transmit buffer underflow, bus-off and test-mode entry. The receive-inversion setting is protected and can only change while the core is in reset mode. The other configuration bits drive their outputs directly, in either mode.

Top module: `can_mode_ctl`

## Requirements
- R1: After a synchronous reset the command byte reads 01h, `op_mode` is 0, every configuration output is 0, and the status byte reads 00h.
- R2: A write of 0 to command bit 0 (reset request) puts the core in operation mode (`op_mode`=1) from the next cycle. A write of 1 returns it to reset mode.
- R3: When any bit of `hw_evt` is 1 (bit 0 underflow, bit 1 bus-off, bit 2 test-mode entry), command bit 0 is 1 after that clock edge, whatever the current mode.
- R4: A hardware event and a software write that clears command bit 0 in the same cycle leave bit 0 set, so the core stays in, or returns to, reset mode.
- R5: Command bit 7 drives `rx_invert`, where 1 means the received line is inverted. It takes the written value only if bit 0 was 1 before the write. In operation mode the bit is left unchanged.
- R6: Command bits 6, 5, 3 and 2 drive `self_test`, `listen_only`, `sleep_en` and `tx_open_drain` in either mode. Bit 2 set to 1 selects open drain and 0 selects push-pull.
- R7: The register word is at address `REG_ADDR`, with the command in bits 7:0 and the status in bits 15:8. `rdata` is registered one cycle after `addr`. Other addresses read 0, and writes to them change nothing. Only lanes with their `be` bit set are written.
- R8: The status byte holds bus status (bit 7), error passive (6), error warning (5), transmit status (4), receive status (3) and sleep-ready (2), sampled from the inputs at each clock edge. Software writes to it have no effect.
- R9: Sleep-ready is 1 exactly when `bus_idle` is 1 and `irq_pending` is 0 in the sampled cycle.
- R10: Command bits 4 and 1 and status bits 1 and 0 always read 0, and writing 1 to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for read and write |
| wr_en | input | 1 | Write strobe |
| be | input | 2 | Byte enables, bit 0 = command lane, bit 1 = status lane |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| hw_evt | input | NUM_EV | Hardware events that force reset mode |
| st_bus | input | 1 | Bus status from the protocol engine |
| st_err_passive | input | 1 | Error passive condition |
| st_err_warn | input | 1 | Error warning condition |
| st_tx | input | 1 | Transmit in progress |
| st_rx | input | 1 | Receive in progress |
| bus_idle | input | 1 | No bus activity seen |
| irq_pending | input | 1 | A core interrupt is pending |
| op_mode | output | 1 | 1 in operation mode, 0 in reset mode |
| rx_invert | output | 1 | Receive line inversion |
| self_test | output | 1 | Self-test, no acknowledge required |
| listen_only | output | 1 | Listen-only mode |
| sleep_en | output | 1 | Sleep enable |
| tx_open_drain | output | 1 | Transmit pad drive, 1 = open drain |

## Verification
Two things can land on the reset-request bit in the same cycle: a hardware event that sets it and a software write that clears it. The bench provokes this collision for each event line, in operation mode and in reset mode. It pairs the event with writes that clear bit 0, and also with writes that try to change the protected inversion bit. The expected result is worked out by a bench model in which the event wins. The model also applies the mode-based protection using the mode from before the write. After each collision the bench reads back `op_mode`, the pad controls and the command byte.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  localparam int CMD_W   = 8;
  localparam int STAT_W  = 8;
  localparam int WORD_W  = CMD_W + STAT_W;
  localparam int LANES   = WORD_W / 8;

  // command byte bit positions
  localparam int B_RSTREQ = 0;
  localparam int B_DRIVE  = 2;
  localparam int B_SLEEP  = 3;
  localparam int B_LISTEN = 5;
  localparam int B_STEST  = 6;
  localparam int B_RXINV  = 7;

  typedef struct packed {
    logic rx_inv;
    logic stest;
    logic listen;
    logic rsv4;
    logic sleep;
    logic drive_od;
    logic rsv1;
    logic rst_req;
  } cmd_t;

  typedef struct packed {
    logic bus;
    logic err_pas;
    logic err_warn;
    logic tx;
    logic rx;
    logic sleep_ok;
    logic [1:0] zero;
  } stat_t;

  localparam cmd_t CMD_RESET = '{rst_req: 1'b1, default: 1'b0};

endpackage

// File: rtl/can_cmd_reg.sv
module can_cmd_reg
  import can_mode_pkg::*;
#(
  parameter int NUM_EV = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cmd,
  input  logic [CMD_W-1:0]  wbyte,
  input  logic [NUM_EV-1:0] hw_evt,
  output cmd_t              cmd_q
);

  logic in_reset;
  logic any_evt;
  cmd_t cmd_d;

  assign in_reset = cmd_q.rst_req;
  assign any_evt  = |hw_evt;

  always_comb begin
    cmd_d = cmd_q;
    if (wr_cmd) begin
      cmd_d.stest    = wbyte[B_STEST];
      cmd_d.listen   = wbyte[B_LISTEN];
      cmd_d.sleep    = wbyte[B_SLEEP];
      cmd_d.drive_od = wbyte[B_DRIVE];
      cmd_d.rst_req  = wbyte[B_RSTREQ];
      if (in_reset) begin
        cmd_d.rx_inv = wbyte[B_RXINV];
      end
    end
    // hardware events win over a clearing write
    if (any_evt) begin
      cmd_d.rst_req = 1'b1;
    end
    cmd_d.rsv4 = 1'b0;
    cmd_d.rsv1 = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_RESET;
    end else begin
      cmd_q <= cmd_d;
    end
  end

endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  st_bus,
  input  logic  st_err_passive,
  input  logic  st_err_warn,
  input  logic  st_tx,
  input  logic  st_rx,
  input  logic  bus_idle,
  input  logic  irq_pending,
  output stat_t stat_q
);

  stat_t stat_d;

  always_comb begin
    stat_d.bus      = st_bus;
    stat_d.err_pas  = st_err_passive;
    stat_d.err_warn = st_err_warn;
    stat_d.tx       = st_tx;
    stat_d.rx       = st_rx;
    stat_d.sleep_ok = bus_idle & ~irq_pending;
    stat_d.zero     = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/can_reg_port.sv
module can_reg_port
  import can_mode_pkg::*;
#(
  parameter int          ADDR_W   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  input  cmd_t              cmd_q,
  input  stat_t             stat_q,
  output logic              wr_cmd,
  output logic [CMD_W-1:0]  wbyte,
  output logic [WORD_W-1:0] rdata
);

  logic              hit;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rd_d;

  assign hit    = (addr == REG_ADDR);
  assign word   = {stat_q, cmd_q};
  // only lane 0 holds writable state; the status lane is read-only
  assign wr_cmd = wr_en & hit & be[0];
  assign wbyte  = wdata[CMD_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_d[g*8 +: 8] = hit ? word[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_d;
    end
  end

endmodule

// File: rtl/can_mode_ctl.sv
module can_mode_ctl
  import can_mode_pkg::*;
#(
  parameter int                ADDR_W   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int                NUM_EV   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        be,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [NUM_EV-1:0] hw_evt,
  input  logic              st_bus,
  input  logic              st_err_passive,
  input  logic              st_err_warn,
  input  logic              st_tx,
  input  logic              st_rx,
  input  logic              bus_idle,
  input  logic              irq_pending,
  output logic              op_mode,
  output logic              rx_invert,
  output logic              self_test,
  output logic              listen_only,
  output logic              sleep_en,
  output logic              tx_open_drain
);

  cmd_t             cmd_q;
  stat_t            stat_q;
  logic             wr_cmd;
  logic [CMD_W-1:0] wbyte;

  can_reg_port #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_port (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .be     (be),
    .wdata  (wdata),
    .cmd_q  (cmd_q),
    .stat_q (stat_q),
    .wr_cmd (wr_cmd),
    .wbyte  (wbyte),
    .rdata  (rdata)
  );

  can_cmd_reg #(
    .NUM_EV (NUM_EV)
  ) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .wr_cmd (wr_cmd),
    .wbyte  (wbyte),
    .hw_evt (hw_evt),
    .cmd_q  (cmd_q)
  );

  can_stat_reg u_stat (
    .clk            (clk),
    .rst            (rst),
    .st_bus         (st_bus),
    .st_err_passive (st_err_passive),
    .st_err_warn    (st_err_warn),
    .st_tx          (st_tx),
    .st_rx          (st_rx),
    .bus_idle       (bus_idle),
    .irq_pending    (irq_pending),
    .stat_q         (stat_q)
  );

  // all outputs come straight from command flops
  assign op_mode       = ~cmd_q.rst_req;
  assign rx_invert     = cmd_q.rx_inv;
  assign self_test     = cmd_q.stest;
  assign listen_only   = cmd_q.listen;
  assign sleep_en      = cmd_q.sleep;
  assign tx_open_drain = cmd_q.drive_od;

endmodule

// File: rtl/can_mode_ctl_chk.sv
module can_mode_ctl_chk #(
  parameter int                ADDR_W   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int                NUM_EV   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [1:0]        be,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic [NUM_EV-1:0] hw_evt,
  input logic              bus_idle,
  input logic              irq_pending,
  input logic              sleep_ok,
  input logic              op_mode,
  input logic              rx_invert
);

  logic clr_wr;
  assign clr_wr = wr_en && (addr == REG_ADDR) && be[0] && !wdata[0];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!op_mode && !rx_invert && rdata == 16'h0000));

  assert_enter_op_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && hw_evt == '0) |=> op_mode);

  assert_evt_forces_reset_R3: assert property (@(posedge clk) disable iff (rst)
    (|hw_evt) |=> !op_mode);

  assert_evt_beats_write_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && (|hw_evt)) |=> !op_mode);

  assert_rxinv_locked_R5: assert property (@(posedge clk) disable iff (rst)
    op_mode |=> $stable(rx_invert));

  assert_sleep_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_idle && !irq_pending) |=> sleep_ok);

  assert_sleep_block_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle || irq_pending) |=> !sleep_ok);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rdata[4] == 1'b0 && rdata[1] == 1'b0 && rdata[9:8] == 2'b00));

endmodule

bind can_mode_ctl can_mode_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR),
  .NUM_EV   (NUM_EV)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr        (addr),
  .wr_en       (wr_en),
  .be          (be),
  .wdata       (wdata),
  .rdata       (rdata),
  .hw_evt      (hw_evt),
  .bus_idle    (bus_idle),
  .irq_pending (irq_pending),
  .sleep_ok    (stat_q.sleep_ok),
  .op_mode     (op_mode),
  .rx_invert   (rx_invert)
);

// File: tb/can_mode_ctl_tb.sv
module can_mode_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int NUM_EV = 3;
  localparam logic [ADDR_W-1:0] RA = '0;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = RA;
  logic              wr_en = 1'b0;
  logic [1:0]        be = 2'b00;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic [NUM_EV-1:0] hw_evt = '0;
  logic st_bus = 0, st_err_passive = 0, st_err_warn = 0, st_tx = 0, st_rx = 0;
  logic bus_idle = 0, irq_pending = 0;
  logic op_mode, rx_invert, self_test, listen_only, sleep_en, tx_open_drain;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_cmd = 8'h01;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(RA), .NUM_EV(NUM_EV)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .be(be), .wdata(wdata),
    .rdata(rdata), .hw_evt(hw_evt), .st_bus(st_bus), .st_err_passive(st_err_passive),
    .st_err_warn(st_err_warn), .st_tx(st_tx), .st_rx(st_rx), .bus_idle(bus_idle),
    .irq_pending(irq_pending), .op_mode(op_mode), .rx_invert(rx_invert),
    .self_test(self_test), .listen_only(listen_only), .sleep_en(sleep_en),
    .tx_open_drain(tx_open_drain)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // model of the command byte after one write cycle
  function automatic logic [7:0] model(input logic [7:0] cur, input logic [7:0] d,
                                       input logic lane0, input logic evt);
    logic [7:0] n;
    n = cur;
    if (lane0) begin
      if (cur[0]) n[7] = d[7];
      n[6] = d[6]; n[5] = d[5]; n[3] = d[3]; n[2] = d[2]; n[0] = d[0];
    end
    n[4] = 1'b0; n[1] = 1'b0;
    if (evt) n[0] = 1'b1;
    return n;
  endfunction

  task automatic check_outputs(input string req);
    check({req, " op_mode"}, op_mode, !exp_cmd[0]);
    check({req, " rx_invert"}, rx_invert, exp_cmd[7]);
    check({req, " self_test"}, self_test, exp_cmd[6]);
    check({req, " listen_only"}, listen_only, exp_cmd[5]);
    check({req, " sleep_en"}, sleep_en, exp_cmd[3]);
    check({req, " tx_open_drain"}, tx_open_drain, exp_cmd[2]);
  endtask

  // one write cycle, then outputs and read-back of the command byte
  task automatic wr(input string req, input logic [ADDR_W-1:0] a, input logic [1:0] b,
                    input logic [15:0] d, input logic [NUM_EV-1:0] ev);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr_en = 1'b1; hw_evt = ev;
    if (a == RA) exp_cmd = model(exp_cmd, d[7:0], b[0], |ev);
    else         exp_cmd = model(exp_cmd, d[7:0], 1'b0, |ev);
    @(negedge clk);
    wr_en = 1'b0; hw_evt = '0; addr = RA; be = 2'b00;
    check_outputs(req);
    @(negedge clk);
    check({req, " readback"}, rdata[7:0], exp_cmd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_outputs("R1");
    check("R1 rdata", rdata, 16'h0001);

    // R2 R5 R6 R10: full byte sweep from reset mode and from operation mode
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        wr("R2 setup", RA, 2'b01, 16'h0001, '0);
        if (m == 1) wr("R2 enter", RA, 2'b01, 16'h0000, '0);
        wr(m == 0 ? "R5/R6/R10 reset-mode write" : "R5/R6/R10 op-mode write",
           RA, 2'b01, 16'(v), '0);
      end
    end

    // R3 R4 collisions of events with clearing and protected writes
    for (int e = 0; e < NUM_EV; e++) begin
      for (int m = 0; m < 2; m++) begin
        wr("R3 setup", RA, 2'b01, 16'h0001, '0);
        if (m == 1) wr("R3 enter", RA, 2'b01, 16'h0000, '0);
        wr("R4 clear+event", RA, 2'b01, 16'h0084, NUM_EV'(1 << e));
        wr("R3 leave", RA, 2'b01, 16'h0000, '0);
        wr("R3 event alone", RA, 2'b00, 16'h0000, NUM_EV'(1 << e));
      end
    end

    // R7 byte lanes and foreign address
    wr("R7 setup", RA, 2'b01, 16'h002C, '0);
    wr("R7 status lane only", RA, 2'b10, 16'hFF00, '0);
    wr("R7 other address", RA + 1'b1, 2'b11, 16'hFFFE, '0);
    @(negedge clk); addr = RA + 1'b1;
    @(negedge clk);
    check("R7 other address reads zero", rdata, 0);
    addr = RA;

    // R8 R9: all status input combinations, with status-lane writes in between
    for (int s = 0; s < 128; s++) begin
      @(negedge clk);
      {st_bus, st_err_passive, st_err_warn, st_tx, st_rx, bus_idle, irq_pending} = 7'(s);
      wr_en = 1'b1; be = 2'b10; wdata = 16'hFFFF;
      @(negedge clk);
      wr_en = 1'b0; be = 2'b00;
      @(negedge clk);
      check("R8/R9 status byte", rdata[15:8],
            {s[6:2], s[1] & ~s[0], 2'b00});
      check("R8 command untouched", rdata[7:0], exp_cmd);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule